// File: doc/BRIEF.md
# Reset Supervisor with Supply and Clock Watch

This block gathers every reason a small microcontroller might need to restart and turns them into one active-low system reset. There are three causes. The first is an active-low pin driven by external circuitry. The second is a supply comparator that reports whether the core supply sits above its reset threshold. The third is a clock watchdog that raises an alarm when the system clock stops toggling. The block records which cause started the most recent reset in a small flag register, so that boot code can read it after restart.

The whole block runs on an always-running reference oscillator, `clk`. It does not run on the system clock it supervises, so the pin and the supply path keep working when the system clock is stopped for sleep. All asynchronous inputs pass through two-flop synchronisers. The system clock is sampled as a level, and each synchronised level change restarts a timeout counter. The reset output goes low on the edge after a synchronised cause appears. It goes high again after a programmable stretch of quiet cycles.

A byte-wide register port runs on the same reference clock. It gives access to two registers. The supply-monitor control register holds the monitor enable, the live status of the two supply comparators and an early-warning interrupt enable. The reset-source register holds the cause flags and the bit that lets a low supply reset the chip. The early-warning interrupt is a level output.

Top module: `rst_supervisor`

## Requirements
- R1: The control register at address 0 reads bit 7 = monitor enable, bit 6 = synchronised "supply above reset threshold", bit 5 = synchronised "supply above warning threshold" and bit 3 = interrupt enable. Bits 7 and 3 are written from the same positions of `wr_data`. After power-on reset the enable is 1 and the interrupt enable is 0.
- R2: Bits 4 and 2:0 of the control register always read 0, and writing 1s to them changes nothing.
- R3: A low supply (`vdd_ok` = 0) resets the system only while both the monitor enable (control bit 7) and the supply select bit (bit 4 of the source register at address 1) are 1. Such a reset sets source flag bit 1.
- R4: A low level on `ext_rst_n`, taken through a two-flop synchroniser, resets the system and sets source flag bit 0. This works even while `sys_clk_in` is stopped.
- R5: If no level change of `sys_clk_in` is seen for `MCD_TIMEOUT` reference cycles, the system is reset and source flag bit 2 is set. Each change restarts the count, so gaps shorter than the timeout cause no reset.
- R6: `sys_rst_n` goes low one cycle after any synchronised cause appears. It goes high `STRETCH` cycles after the last cause clears. Measured from a pin release, that is `STRETCH`+2 reference clock edges.
- R7: A reset that starts from a released state loads the flags with exactly the causes active at that moment, which clears the others. Causes that appear while a reset is in progress are added. Flags stay unchanged between resets.
- R8: `warn_irq` is 1 exactly while the interrupt enable is 1 and the synchronised warning status is 0.
- R9: In the source register only bit 4 (supply select, power-on value 0) is writable. Flag bits 2:0 ignore writes. Bits 7:5 and 3 read 0. Addresses 2 and 3 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| sys_clk_in | input | 1 | Supervised system clock, sampled as a level |
| vdd_ok | input | 1 | Comparator: supply above reset threshold |
| vdd_warn_ok | input | 1 | Comparator: supply above early-warning threshold |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (combinational from `addr`) |
| sys_rst_n | output | 1 | System reset, active low |
| warn_irq | output | 1 | Early-warning interrupt level |

## Verification
Embedded assertions check the following on every cycle:
- any synchronised cause forces the reset low on the next edge;
- the reset is released only after a quiet cycle;
- a fresh reset loads the flags with exactly the active causes, and the flags hold while no cause is active;
- the watch counter stays within its limit;
- a supply flag can only rise when both the enable and the select were set.

Only the bench scenarios can show the behaviour seen at the ports: the exact release delay after a pin pulse, that the timeout triggers while shorter random gaps do not, that causes coincide or accumulate within one reset, that the pin works with the system clock stopped, and the register masking under random writes.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  localparam int CTRL_ADDR = 0;
  localparam int SRC_ADDR  = 1;

  localparam int CTRL_EN_BIT  = 7;
  localparam int CTRL_VOK_BIT = 6;
  localparam int CTRL_WOK_BIT = 5;
  localparam int CTRL_IE_BIT  = 3;

  localparam int SRC_PIN_BIT = 0;
  localparam int SRC_SUP_BIT = 1;
  localparam int SRC_CLK_BIT = 2;
  localparam int SRC_SEL_BIT = 4;

  // cause vector: field order matches flag bit order (pin = bit 0)
  typedef struct packed {
    logic clk;
    logic sup;
    logic pin;
  } cause_t;

  function automatic logic [7:0] pack_ctrl(input logic en, input logic vok,
                                           input logic wok, input logic ie);
    logic [7:0] v;
    v = '0;
    v[CTRL_EN_BIT]  = en;
    v[CTRL_VOK_BIT] = vok;
    v[CTRL_WOK_BIT] = wok;
    v[CTRL_IE_BIT]  = ie;
    return v;
  endfunction

  function automatic logic [7:0] pack_src(input cause_t fl, input logic sel);
    logic [7:0] v;
    v = '0;
    v[SRC_PIN_BIT] = fl.pin;
    v[SRC_SUP_BIT] = fl.sup;
    v[SRC_CLK_BIT] = fl.clk;
    v[SRC_SEL_BIT] = sel;
    return v;
  endfunction

  // fresh reset replaces the record, an ongoing one accumulates
  function automatic cause_t merge_flags(input cause_t cur, input cause_t now,
                                         input logic fresh);
    return fresh ? now : (cur | now);
  endfunction

endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[0] <= RST_VAL;
          else        st[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[g] <= RST_VAL;
          else        st[g] <= st[g-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/rsv_clk_watch.sv
module rsv_clk_watch #(
  parameter int TIMEOUT = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic edge_seen,
  output logic fire
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic          prev_q;
  logic [CW-1:0] cnt_q;

  assign edge_seen = lvl ^ prev_q;
  assign fire      = (cnt_q == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= lvl;
      if (edge_seen)        cnt_q <= '0;
      else if (!fire)       cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  p_edge_quiets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> !fire);
endmodule

// File: rtl/rsv_stretch.sv
module rsv_stretch #(
  parameter int STRETCH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cause_any,
  output logic in_rst,
  output logic fresh
);
  localparam int SW = $clog2(STRETCH + 1);
  localparam logic [SW-1:0] LAST = SW'(STRETCH - 1);

  logic [SW-1:0] cnt_q;

  assign fresh = cause_any & ~in_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_rst <= 1'b1;
      cnt_q  <= '0;
    end else if (cause_any) begin
      in_rst <= 1'b1;
      cnt_q  <= '0;
    end else if (in_rst) begin
      if (cnt_q == LAST) begin
        in_rst <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_assert_on_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cause_any |=> in_rst);
  p_release_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_rst) |-> $past(!cause_any));
endmodule

// File: rtl/rsv_regs.sv
module rsv_regs
  import rsv_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              vok_s,
  input  logic              wok_s,
  input  cause_t            causes,
  input  logic              cause_any,
  input  logic              fresh,
  output logic [7:0]        rd_data,
  output logic              mon_en,
  output logic              sup_sel,
  output logic              irq_en,
  output cause_t            flags
);
  logic wr_ctrl, wr_src;
  logic unused_wr_bits;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(CTRL_ADDR));
  assign wr_src  = wr_en && (addr == ADDR_W'(SRC_ADDR));
  assign unused_wr_bits = ^{wr_data[6:5], wr_data[2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_en  <= 1'b1;
      irq_en  <= 1'b0;
      sup_sel <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mon_en <= wr_data[CTRL_EN_BIT];
        irq_en <= wr_data[CTRL_IE_BIT];
      end
      if (wr_src) sup_sel <= wr_data[SRC_SEL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flags <= '0;
    else if (cause_any) flags <= merge_flags(flags, causes, fresh);
  end

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(CTRL_ADDR))
      rd_data = pack_ctrl(mon_en, vok_s, wok_s, irq_en);
    else if (addr == ADDR_W'(SRC_ADDR))
      rd_data = pack_src(flags, sup_sel);
  end

  p_ctrl_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (mon_en == $past(wr_data[CTRL_EN_BIT])) &&
                (irq_en == $past(wr_data[CTRL_IE_BIT])));
  p_flag_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |=> flags == $past(causes));
  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_any |=> $stable(flags));
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsv_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int MCD_TIMEOUT = 25000,
  parameter int STRETCH     = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_n,
  input  logic              sys_clk_in,
  input  logic              vdd_ok,
  input  logic              vdd_warn_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              sys_rst_n,
  output logic              warn_irq
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw_in, syn;
  logic pin_s, vok_s, wok_s, sclk_s;
  logic mcd_fire, mcd_edge;
  logic mon_en, sup_sel, irq_en;
  logic in_rst, fresh, cause_any;
  cause_t causes, flags;

  assign raw_in = {sys_clk_in, vdd_warn_ok, vdd_ok, ext_rst_n};

  rsv_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)) u_sync (
    .clk(clk), .rst_n(por_n), .d(raw_in), .q(syn)
  );

  assign {sclk_s, wok_s, vok_s, pin_s} = syn;

  rsv_clk_watch #(.TIMEOUT(MCD_TIMEOUT)) u_watch (
    .clk(clk), .rst_n(por_n), .lvl(sclk_s),
    .edge_seen(mcd_edge), .fire(mcd_fire)
  );

  assign causes.pin = ~pin_s;
  assign causes.sup = mon_en & sup_sel & ~vok_s;
  assign causes.clk = mcd_fire;
  assign cause_any  = |causes;

  rsv_stretch #(.STRETCH(STRETCH)) u_stretch (
    .clk(clk), .rst_n(por_n), .cause_any(cause_any),
    .in_rst(in_rst), .fresh(fresh)
  );

  rsv_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(por_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .vok_s(vok_s), .wok_s(wok_s), .causes(causes), .cause_any(cause_any),
    .fresh(fresh), .rd_data(rd_data), .mon_en(mon_en), .sup_sel(sup_sel),
    .irq_en(irq_en), .flags(flags)
  );

  assign sys_rst_n = ~in_rst;
  assign warn_irq  = irq_en & ~wok_s;

  p_supply_gate_r3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(flags.sup) |-> $past(mon_en && sup_sel));
  p_irq_needs_ie_r8: assert property (@(posedge clk) disable iff (!por_n)
    warn_irq |-> irq_en);
  p_clk_flag_src_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(flags.clk) |-> $past(mcd_fire) && !$past(mcd_edge));
endmodule

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;
  localparam int AW = 2;
  localparam int TO = 40;
  localparam int ST = 8;

  logic clk = 1'b0, por_n = 1'b0, ext_rst_n = 1'b1, sys_clk_in = 1'b0;
  logic vdd_ok = 1'b1, vdd_warn_ok = 1'b1, wr_en = 1'b0, sys_run = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic sys_rst_n, warn_irq;
  int checks = 0, errors = 0;
  logic m_en = 1'b1, m_ie = 1'b0, m_sel = 1'b0;

  rst_supervisor #(.ADDR_W(AW), .MCD_TIMEOUT(TO), .STRETCH(ST)) u_rst_supervisor (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .sys_clk_in(sys_clk_in),
    .vdd_ok(vdd_ok), .vdd_warn_ok(vdd_warn_ok), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .sys_rst_n(sys_rst_n), .warn_irq(warn_irq)
  );

  always #2 clk = ~clk;
  always #10 if (sys_run) sys_clk_in = ~sys_clk_in;

  function automatic logic [7:0] want_ctrl(logic en, logic vok, logic wok, logic ie);
    return {en, vok, wok, 1'b0, ie, 3'b000};
  endfunction
  function automatic logic [7:0] want_src(logic [2:0] fl, logic sel);
    return {3'b000, sel, 1'b0, fl};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 0) begin m_en = d[7]; m_ie = d[3]; end
    if (a == 1) m_sel = d[4];
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; #1; d = rd_data;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int n;
    void'($urandom(32'd12345));
    cyc(3);
    chk("R6 low during power-on", sys_rst_n, 0);
    por_n = 1'b1;
    cyc(ST + 6);
    chk("R6 released after power-on", sys_rst_n, 1);
    rd(0, d); chk("R1 ctrl power-on value", d, want_ctrl(1, 1, 1, 0));
    rd(1, d); chk("R9 src power-on value", d, 8'h00);
    chk("R8 irq off after power-on", warn_irq, 0);

    // R2: padding bits
    wr(0, 8'hFF); rd(0, d); chk("R2 ctrl write ones", d, want_ctrl(1, 1, 1, 1));
    wr(0, 8'h17); rd(0, d); chk("R2 ctrl pad ignored", d, want_ctrl(0, 1, 1, 0));

    // R1/R8 random: sel is 0 so supply level is harmless
    for (int i = 0; i < 24; i++) begin
      logic [7:0] w;
      logic wok, vok;
      w = 8'($urandom); wok = 1'($urandom); vok = 1'($urandom);
      wr(0, w);
      @(negedge clk); vdd_warn_ok = wok; vdd_ok = vok;
      cyc(3);
      rd(0, d); chk("R1 ctrl random", d, want_ctrl(w[7], vok, wok, w[3]));
      chk("R8 irq level", warn_irq, w[3] & ~wok);
      chk("R3 no reset without select", sys_rst_n, 1);
    end
    vdd_ok = 1'b1; vdd_warn_ok = 1'b1;

    // R9 source register writes
    wr(1, 8'hEF); rd(1, d); chk("R9 flags read-only", d, 8'h00);
    wr(3, 8'hFF); rd(2, d); chk("R9 unused addr reads zero", d, 8'h00);
    rd(0, d); chk("R9 unused addr write ignored", d, want_ctrl(m_en, 1, 1, m_ie));

    // R3 gating
    wr(1, 8'h00); wr(0, 8'h80);
    @(negedge clk); vdd_ok = 1'b0; cyc(12);
    chk("R3 enable only", sys_rst_n, 1);
    rd(0, d); chk("R1 live supply status", d, want_ctrl(1, 0, 1, 0));
    wr(0, 8'h00); wr(1, 8'h10); cyc(12);
    chk("R3 select only", sys_rst_n, 1);
    wr(0, 8'h80); cyc(3);
    chk("R3 enable and select reset", sys_rst_n, 0);
    vdd_ok = 1'b1; cyc(ST + 10);
    chk("R6 release after supply", sys_rst_n, 1);
    rd(1, d); chk("R3 supply flag", d, want_src(3'b010, 1));

    // R4/R6 pin pulse and exact release delay
    @(negedge clk); ext_rst_n = 1'b0; cyc(5);
    chk("R4 pin asserts reset", sys_rst_n, 0);
    ext_rst_n = 1'b1; n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!sys_rst_n && n < 100);
    chk("R6 stretch edges", n, ST + 2);
    rd(1, d); chk("R7 pin flag replaces supply", d, want_src(3'b001, 1));
    cyc(20); rd(1, d); chk("R7 flags sticky", d, want_src(3'b001, 1));

    // R7 coinciding causes
    @(negedge clk); ext_rst_n = 1'b0; vdd_ok = 1'b0; cyc(5);
    ext_rst_n = 1'b1; vdd_ok = 1'b1; cyc(ST + 10);
    rd(1, d); chk("R7 coinciding causes", d, want_src(3'b011, 1));

    // R5 short random gaps do not fire
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sys_run = 1'b0;
      cyc(int'($urandom_range(TO - 12, 1)));
      sys_run = 1'b1; cyc(6);
      chk("R5 short gap no reset", sys_rst_n, 1);
    end

    // R5 timeout
    @(negedge clk); sys_run = 1'b0; cyc(TO - 6);
    chk("R5 before timeout", sys_rst_n, 1);
    cyc(16);
    chk("R5 timeout reset", sys_rst_n, 0);
    sys_run = 1'b1; cyc(ST + 12);
    chk("R6 release after clock returns", sys_rst_n, 1);
    rd(1, d); chk("R5 clock flag", d, want_src(3'b100, 1));

    // R4 pin with clock stopped; R7 clock cause added during reset
    @(negedge clk); sys_run = 1'b0; ext_rst_n = 1'b0; cyc(4);
    chk("R4 pin works with clock stopped", sys_rst_n, 0);
    cyc(TO + 20);
    ext_rst_n = 1'b1; sys_run = 1'b1; cyc(ST + 14);
    chk("R6 release after pin and clock", sys_rst_n, 1);
    rd(1, d); chk("R7 accumulated causes", d, want_src(3'b101, 1));

    finish_run();
  end
endmodule